// File: doc/BRIEF.md
# Load-Stride Prefetch Engine

This block observes the loads a core issues, each presented as the load's program counter together with the data address it touched. It keeps a small direct-mapped table, indexed and tagged by the program counter. Each entry holds the last address that load used, the most recent stride between two of its addresses and a small saturating confidence count. When a load keeps moving by the same non-zero stride and its confidence reaches the threshold, the engine produces a burst of prefetch addresses. The burst begins a programmable number of strides ahead of the current access, so the prefetch can arrive before the demand access does.

Prefetch addresses leave on a valid/ready stream, one per accepted handshake. While a burst is still draining, the engine stops taking new load observations. Sending the requests to memory and filling any cache are the job of the logic downstream.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset every table entry is empty, `pf_valid` is 0 and `obs_ready` is 1.
- R2: The table has 16 entries, selected by `obs_pc[5:2]`. When the stored tag (`obs_pc[31:6]`) differs from the incoming one, or the entry is empty, the entry is rewritten with the new PC and address, a stride of 0 and a confidence of 0, and no prefetch is produced.
- R3: On a tag hit the new stride is `obs_addr` minus the stored last address, modulo 2^32, and the stored last address becomes `obs_addr`.
- R4: Confidence is a 2-bit saturating count. It rises by one when the new stride equals the stored stride. Otherwise it falls by one (stopping at 0) and the new stride replaces the stored one. A burst starts only on a hit whose stride repeated and whose updated confidence is 2 or more. A steady stride therefore first prefetches on the fourth access of that load.
- R5: The first address of a burst is `obs_addr + D*stride`, where D is `cfg_distance`. A `cfg_distance` of 0 is treated as 1.
- R6: A burst holds `cfg_degree` addresses, sampled when the trigger is accepted. Each address is the previous one plus the stride, and one address is offered per cycle. `pf_valid` rises in the cycle after the triggering observation is accepted.
- R7: A stride of 0 never produces a prefetch, whatever the confidence.
- R8: While `pf_valid` is 1 and `pf_ready` is 0, `pf_addr` holds and `pf_valid` stays 1.
- R9: `obs_ready` is 0 exactly while a burst has addresses left to send. An observation is accepted only when `obs_valid` and `obs_ready` are both 1.
- R10: Negative strides (two's complement differences) are followed in the same way as positive ones.
- R11: A `cfg_degree` of 0 suppresses the burst while the table still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | Load observation present |
| obs_ready | output | 1 | Engine can take an observation |
| obs_pc | input | 32 | Program counter of the load |
| obs_addr | input | 32 | Data address the load touched |
| cfg_distance | input | 4 | Strides ahead of the first prefetch |
| cfg_degree | input | 3 | Prefetches per trigger |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | 32 | Prefetch address |

## Verification
A behavioural model in the bench is compared with the design on every clock. It is driven by several kinds of load traffic:
- A steady positive stride shows when confidence is first reached and which address the prefetch targets.
- A stride change in the middle of a run, followed by a negative stride, shows that confidence decays and that the subtraction wraps correctly.
- A repeated identical address shows that a zero stride is suppressed.
- Two PCs that alias to one entry, interleaved, show that replacement resets the learned state.
- Bursts of several addresses with random consumer stalls separate one-per-cycle stepping and stall holding from the observe-side backpressure. Degree and distance of zero are also tried.

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 16,
  parameter int CONF_W   = 2,
  parameter int CONF_MIN = 2,
  parameter int DIST_W   = 4,
  parameter int DEG_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  output logic              obs_ready,
  input  logic [PC_W-1:0]   obs_pc,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic [DIST_W-1:0] cfg_distance,
  input  logic [DEG_W-1:0]  cfg_degree,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
  localparam logic [CONF_W-1:0] CONF_TH  = CONF_W'(CONF_MIN);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  last_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];
  logic [CONF_W-1:0]  conf_q   [ENTRIES];

  logic [DEG_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              accept, hit, same, fire;
  logic [ADDR_W-1:0] new_stride, first_addr;
  logic [DIST_W-1:0] eff_dist;
  logic [CONF_W-1:0] conf_cur, conf_nx;

  assign idx        = obs_pc[IDX_W+1:2];
  assign tag        = obs_pc[PC_W-1:IDX_W+2];
  assign obs_ready  = (left_q == '0);
  assign accept     = obs_valid && obs_ready;
  assign hit        = vld_q[idx] && (tag_q[idx] == tag);
  assign new_stride = obs_addr - last_q[idx];
  assign same       = (new_stride == stride_q[idx]);
  assign conf_cur   = conf_q[idx];
  assign eff_dist   = (cfg_distance == '0) ? DIST_W'(1) : cfg_distance;
  assign first_addr = obs_addr + ADDR_W'(eff_dist) * new_stride;

  always_comb begin
    if (!hit)                    conf_nx = '0;
    else if (same)               conf_nx = (conf_cur == CONF_MAX) ? conf_cur : conf_cur + 1'b1;
    else                         conf_nx = (conf_cur == '0) ? conf_cur : conf_cur - 1'b1;
  end

  assign fire = accept && hit && same && (new_stride != '0) &&
                (conf_nx >= CONF_TH) && (cfg_degree != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (accept) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q[idx]    <= tag;
      last_q[idx]   <= obs_addr;
      stride_q[idx] <= hit ? new_stride : '0;
      conf_q[idx]   <= conf_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
      step_q <= '0;
    end else if (fire) begin
      left_q <= cfg_degree;
      addr_q <= first_addr;
      step_q <= new_stride;
    end else if (pf_valid && pf_ready) begin
      left_q <= left_q - 1'b1;
      addr_q <= addr_q + step_q;
    end
  end

  assign pf_valid = (left_q != '0);
  assign pf_addr  = addr_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !obs_ready);

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && (left_q > DEG_W'(1)) |=> pf_valid && (pf_addr == $past(pf_addr) + step_q));

  assert_nozero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (step_q != '0));

  // R4: a burst opens only right after an accepted observation
  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid ##1 pf_valid |-> $past(obs_valid) && $past(obs_ready));
endmodule

// File: tb/stride_prefetcher_test.sv
module stride_prefetcher_test;
  logic clk = 0, rst_n = 0;
  logic obs_valid = 0, pf_ready = 1;
  logic [31:0] obs_pc = 0, obs_addr = 0;
  logic [3:0] cfg_distance = 1;
  logic [2:0] cfg_degree = 1;
  logic obs_ready, pf_valid;
  logic [31:0] pf_addr;

  always #4 clk = ~clk;

  stride_prefetcher uut (.clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_ready(obs_ready),
    .obs_pc(obs_pc), .obs_addr(obs_addr), .cfg_distance(cfg_distance), .cfg_degree(cfg_degree),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  int checks = 0, errors = 0;
  string cur_tag = "R1";
  bit stall_mode = 0;

  bit          m_vld [16];
  logic [31:0] m_pc  [16];
  logic [31:0] m_last[16];
  logic [31:0] m_str [16];
  int          m_conf[16];
  logic [31:0] m_q[$];
  bit acc_evt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_vld[i]) m_vld[i] = 0;
      m_q.delete();
      acc_evt = 0;
    end else begin
      bit acc;
      acc = obs_valid && (m_q.size() == 0);
      if (m_q.size() != 0 && pf_ready) void'(m_q.pop_front());
      acc_evt = acc;
      if (acc) begin
        int i;
        i = obs_pc[5:2];
        if (!m_vld[i] || m_pc[i] != obs_pc) begin
          m_vld[i] = 1; m_pc[i] = obs_pc; m_str[i] = 0; m_conf[i] = 0;
        end else begin
          logic [31:0] s;
          s = obs_addr - m_last[i];
          if (s == m_str[i]) begin
            if (m_conf[i] < 3) m_conf[i]++;
            if (s != 0 && m_conf[i] >= 2 && cfg_degree != 0) begin
              int d;
              d = (cfg_distance == 0) ? 1 : int'(cfg_distance);
              for (int k = 0; k < int'(cfg_degree); k++)
                m_q.push_back(obs_addr + s * 32'(d + k));
            end
          end else begin
            if (m_conf[i] > 0) m_conf[i]--;
            m_str[i] = s;
          end
        end
        m_last[i] = obs_addr;
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("obs_ready", 32'(obs_ready), 32'(m_q.size() == 0));
    check("pf_valid", 32'(pf_valid), 32'(m_q.size() != 0));
    if (m_q.size() != 0 && pf_valid) check("pf_addr", pf_addr, m_q[0]);
    pf_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;
  end

  task automatic observe(logic [31:0] pc, logic [31:0] a);
    @(negedge clk);
    obs_valid = 1; obs_pc = pc; obs_addr = a;
    do @(negedge clk); while (!acc_evt);
    obs_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    check("reset obs_ready", 32'(obs_ready), 1);
    check("reset pf_valid", 32'(pf_valid), 0);

    cur_tag = "R3 R4 R5";
    for (int k = 0; k < 7; k++) begin observe(32'h0000_1000, 32'h8000 + 32'(k) * 64); idle(3); end
    cur_tag = "R4 stride change";
    observe(32'h0000_1000, 32'h9000);
    for (int k = 1; k < 6; k++) begin observe(32'h0000_1000, 32'h9000 + 32'(k) * 8); idle(2); end

    cur_tag = "R10 negative";
    cfg_distance = 3;
    for (int k = 0; k < 6; k++) begin observe(32'h0000_2004, 32'h0000_0100 - 32'(k) * 32'h40); idle(4); end

    cur_tag = "R7 zero stride";
    for (int k = 0; k < 6; k++) begin observe(32'h0000_2008, 32'h4444); idle(2); end

    cur_tag = "R2 alias";
    for (int k = 0; k < 8; k++) begin
      observe(32'h0000_300C, 32'h1_0000 + 32'(k) * 16);
      observe(32'h0000_304C, 32'h2_0000 + 32'(k) * 16);
      idle(2);
    end

    cur_tag = "R6 R8 R9 burst";
    cfg_distance = 2; cfg_degree = 5; stall_mode = 1;
    for (int k = 0; k < 10; k++) observe(32'h0000_4010, 32'h5_0000 + 32'(k) * 128);
    idle(20);
    cfg_degree = 7;
    for (int k = 0; k < 6; k++) observe(32'h0000_4010, 32'h5_0000 + 32'(k + 10) * 128);
    idle(30);
    stall_mode = 0;

    cur_tag = "R11 degree zero";
    cfg_degree = 0;
    for (int k = 0; k < 6; k++) begin observe(32'h0000_5014, 32'h7000 + 32'(k) * 4); idle(2); end
    cur_tag = "R5 distance zero";
    cfg_degree = 2; cfg_distance = 0;
    observe(32'h0000_5014, 32'h7018);
    idle(5);
    observe(32'h0000_5014, 32'h701C);
    idle(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule